// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block carries out a whole block-erase on a NAND flash device that sits on an 8-bit command, address and data port. The host gives it a one-cycle start pulse and a 24-bit block address. The sequencer then drives the bus with no further help from the host. It sends the erase-setup command and three address bytes, least significant byte first. Next it sends the erase-confirm command. It waits for the device to report ready, sends the status-read command, and reads back one status byte.

Every bus cycle is a single clock cycle. A cycle is marked by exactly one of three strobes: command write, address write or data read. The byte for a command or address cycle goes out on a shared output bus.

Ready can arrive in two ways: as a level on a ready line, or as a one-cycle ready event. A programmable cycle limit ends the wait if ready never comes. When the operation ends, the block pulses done and presents the captured status byte, a fail flag and a timeout flag. These three results stay valid until the next start is accepted.

Top module: `nand_erase_seq`

## Requirements
- R1: A start pulse sampled high while the block is idle makes the next cycle a command cycle: cmd_we_o is 1 and bus_o is 0x60.
- R2: Exactly three address cycles follow the setup command, one per cycle. In each, addr_we_o is 1 and cmd_we_o is 0. They carry block address bits [7:0], then [15:8], then [23:16].
- R3: The cycle after the third address byte is a command cycle with bus_o equal to 0xD0.
- R4: After the confirm command the block stays in its wait phase, with no strobe active, until it samples rdy_i high or rdy_evt_i high.
- R5: The cycle after ready is sampled is a command cycle with bus_o equal to 0x70.
- R6: The cycle after the 0x70 command is a read cycle: rd_o is 1 and bus_o is 0x00. The value on status_i in that cycle is captured and shown on status_o.
- R7: done_o is a one-cycle pulse in the cycle after the read cycle. In that cycle fail_o equals status bit 0, where 1 means the erase failed.
- R8: If ready is never sampled, the wait phase lasts exactly TIMEOUT_CYCLES cycles. done_o then rises with timeout_o and fail_o set and status_o at 0x00, and no 0x70 command or read cycle is issued. Ready seen in the last wait cycle still wins over the timeout.
- R9: A start pulse while the block is not idle is ignored: it adds no bus cycles and does not restart the sequence.
- R10: busy_o is 1 from the cycle after an accepted start through the done cycle, and 0 in the cycle after done.
- R11: While reset is asserted, every strobe, busy_o, done_o, fail_o, timeout_o, bus_o and status_o read 0.
- R12: At most one of cmd_we_o, addr_we_o and rd_o is 1 in any cycle.
- R13: The block address is captured when start is accepted. Later changes on blk_addr_i do not affect the address bytes that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| blk_addr_i | input | 24 | Block address to erase |
| rdy_i | input | 1 | Device ready level, 1 = ready |
| rdy_evt_i | input | 1 | One-cycle ready event |
| status_i | input | 8 | Data returned by the device on a read cycle |
| cmd_we_o | output | 1 | Command latch strobe |
| addr_we_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Data read strobe |
| bus_o | output | 8 | Command or address byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete pulse |
| fail_o | output | 1 | Erase failed or timed out |
| timeout_o | output | 1 | Ready never arrived |
| status_o | output | 8 | Captured status byte |

## Verification
Count the cycles from the clock edge that accepts start. The setup command is due 1 cycle after that edge, the address bytes in cycles 2 to 4, the confirm command in cycle 5, and the wait phase starts in cycle 6.

The 0x70 command comes one cycle after the edge that samples ready. The read follows one cycle later, and done one cycle after the read. On a timeout, done comes exactly TIMEOUT_CYCLES cycles after the wait phase begins.

The driver drives inputs on falling edges and queues the expected bus events and results. The monitor samples on the falling edge in the middle of each cycle and pops one item for each strobe or done it sees. Any extra, missing or misplaced cycle therefore shows up as a mismatch.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  localparam logic [7:0] OP_SETUP   = 8'h60;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_CONFIRM,
    ST_WAIT,
    ST_STATCMD,
    ST_READ,
    ST_DONE
  } nes_state_e;
endpackage

// File: rtl/nes_wait_timer.sv
module nes_wait_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/nes_ctrl.sv
module nes_ctrl
  import nand_erase_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  localparam int unsigned IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic             expire_i,
  output nes_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             abort_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  nes_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign state_o   = state_q;
  assign idx_o     = idx_q;
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign capture_o = (state_q == ST_READ);
  assign abort_o   = (state_q == ST_WAIT) && !ready_i && expire_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = ST_ADDR;
        idx_d   = '0;
      end
      ST_ADDR: begin
        if (idx_q == LAST_IDX) state_d = ST_CONFIRM;
        else                   idx_d   = idx_q + IDX_W'(1);
      end
      ST_CONFIRM: state_d = ST_WAIT;
      // ready wins over expiry in the same cycle
      ST_WAIT: begin
        if (ready_i)       state_d = ST_STATCMD;
        else if (expire_i) state_d = ST_DONE;
      end
      ST_STATCMD: state_d = ST_READ;
      ST_READ:    state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/nes_bus_drv.sv
module nes_bus_drv
  import nand_erase_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned IDX_W      = 2,
  localparam int unsigned ADDR_W    = DATA_W * ADDR_BYTES
) (
  input  nes_state_e        state_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_we_o,
  output logic              addr_we_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] bus_o
);
  logic [DATA_W-1:0] addr_byte [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    assign addr_byte[g] = addr_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    cmd_we_o  = 1'b0;
    addr_we_o = 1'b0;
    rd_o      = 1'b0;
    bus_o     = '0;
    unique case (state_i)
      ST_SETUP: begin
        cmd_we_o = 1'b1;
        bus_o    = DATA_W'(OP_SETUP);
      end
      ST_ADDR: begin
        addr_we_o = 1'b1;
        bus_o     = addr_byte[idx_i];
      end
      ST_CONFIRM: begin
        cmd_we_o = 1'b1;
        bus_o    = DATA_W'(OP_CONFIRM);
      end
      ST_STATCMD: begin
        cmd_we_o = 1'b1;
        bus_o    = DATA_W'(OP_STATUS);
      end
      ST_READ: rd_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned ADDR_BYTES     = 3,
  parameter int unsigned TIMEOUT_CYCLES = 4096,
  localparam int unsigned ADDR_W        = DATA_W * ADDR_BYTES,
  localparam int unsigned IDX_W         = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] blk_addr_i,
  input  logic              rdy_i,
  input  logic              rdy_evt_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              cmd_we_o,
  output logic              addr_we_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] status_o
);
  nes_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              accept, capture, abort, expire, ready;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] status_q;
  logic              fail_q, tmo_q;

  assign ready = rdy_i || rdy_evt_i;

  nes_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ready_i   (ready),
    .expire_i  (expire),
    .state_o   (state),
    .idx_o     (idx),
    .accept_o  (accept),
    .capture_o (capture),
    .abort_o   (abort)
  );

  nes_wait_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state == ST_WAIT),
    .expire_o (expire)
  );

  nes_bus_drv #(
    .DATA_W     (DATA_W),
    .ADDR_BYTES (ADDR_BYTES),
    .IDX_W      (IDX_W)
  ) u_bus (
    .state_i   (state),
    .idx_i     (idx),
    .addr_i    (addr_q),
    .cmd_we_o  (cmd_we_o),
    .addr_we_o (addr_we_o),
    .rd_o      (rd_o),
    .bus_o     (bus_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      status_q <= '0;
      fail_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else if (accept) begin
      addr_q   <= blk_addr_i;
      status_q <= '0;
      fail_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else if (capture) begin
      status_q <= status_i;
      fail_q   <= status_i[0];
    end else if (abort) begin
      fail_q <= 1'b1;
      tmo_q  <= 1'b1;
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;
  assign status_o  = status_q;
endmodule

// File: rtl/nes_checker.sv
module nes_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cmd_we_o,
  input logic              addr_we_o,
  input logic              rd_o,
  input logic [DATA_W-1:0] bus_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              timeout_o
);
  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_we_o, addr_we_o, rd_o}));

  a_r1_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (cmd_we_o && bus_o == DATA_W'(8'h60)));

  a_r3_confirm_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && bus_o == DATA_W'(8'hD0)) |-> $past(addr_we_o));

  a_r6_read_after_status_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && bus_o == DATA_W'(8'h70)) |=> rd_o);

  a_r7_done_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> done_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r10_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r8_timeout_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fail_o);
endmodule

bind nand_erase_seq nes_checker #(.DATA_W(DATA_W)) u_nes_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .cmd_we_o  (cmd_we_o),
  .addr_we_o (addr_we_o),
  .rd_o      (rd_o),
  .bus_o     (bus_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .timeout_o (timeout_o)
);

// File: tb/nand_erase_seq_bench.sv
module nand_erase_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] blk_addr_i = '0;
  logic        rdy_i = 1'b0;
  logic        rdy_evt_i = 1'b0;
  logic [7:0]  status_i = '0;
  logic        cmd_we_o, addr_we_o, rd_o, busy_o, done_o, fail_o, timeout_o;
  logic [7:0]  bus_o, status_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // {kind, byte}: kind 1 = command, 2 = address, 3 = read
  logic [9:0]  exp_bus[$];
  // {status, fail, timeout}
  logic [9:0]  exp_res[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nand_erase_seq #(.TIMEOUT_CYCLES(TMO)) u_nand_erase_seq (
    .clk_i, .rst_ni, .start_i, .blk_addr_i, .rdy_i, .rdy_evt_i, .status_i,
    .cmd_we_o, .addr_we_o, .rd_o, .bus_o, .busy_o, .done_o, .fail_o,
    .timeout_o, .status_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R12 one strobe", 32'($countones({cmd_we_o, addr_we_o, rd_o}) <= 1), 32'd1);
      if (cmd_we_o || addr_we_o || rd_o) begin
        logic [1:0] kind;
        logic [9:0] e;
        string      req;
        kind = cmd_we_o ? 2'd1 : (addr_we_o ? 2'd2 : 2'd3);
        if (exp_bus.size() == 0) begin
          check("R9 unexpected bus cycle", {22'd0, kind, bus_o}, 32'd0);
        end else begin
          e = exp_bus.pop_front();
          if (e[9:8] == 2'd2)       req = "R2 R13 address byte";
          else if (e[9:8] == 2'd3)  req = "R6 read cycle";
          else if (e[7:0] == 8'h60) req = "R1 setup command";
          else if (e[7:0] == 8'hD0) req = "R3 confirm command";
          else                      req = "R5 status command";
          check(req, {22'd0, kind, bus_o}, {22'd0, e});
        end
      end
      if (done_o) begin
        if (exp_res.size() == 0) begin
          check("R7 unexpected done", 32'd1, 32'd0);
        end else begin
          logic [9:0] r;
          r = exp_res.pop_front();
          check("R6 R7 R8 result", {22'd0, status_o, fail_o, timeout_o}, {22'd0, r});
        end
      end
    end
  end

  // driver
  task automatic run_erase(input logic [23:0] addr, input logic [7:0] st,
                           input int delay, input bit use_evt, input bit tmo,
                           input bit poke);
    exp_bus.push_back({2'd1, 8'h60});
    exp_bus.push_back({2'd2, addr[7:0]});
    exp_bus.push_back({2'd2, addr[15:8]});
    exp_bus.push_back({2'd2, addr[23:16]});
    exp_bus.push_back({2'd1, 8'hD0});
    if (tmo) begin
      exp_res.push_back({8'h00, 1'b1, 1'b1});
    end else begin
      exp_bus.push_back({2'd1, 8'h70});
      exp_bus.push_back({2'd3, 8'h00});
      exp_res.push_back({st, st[0], 1'b0});
    end
    @(negedge clk_i);
    start_i = 1'b1; blk_addr_i = addr; status_i = st;
    @(negedge clk_i);
    start_i = 1'b0; blk_addr_i = ~addr;
    check("R10 busy after start", 32'(busy_o), 32'd1);
    if (poke) begin
      @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check("R9 busy kept", 32'(busy_o), 32'd1);
      repeat (3) @(negedge clk_i);
    end else begin
      repeat (5) @(negedge clk_i);
    end
    if (tmo) begin
      int n = 0;
      while (!done_o && n < TMO + 10) begin
        check("R4 no strobe in wait", 32'(cmd_we_o | addr_we_o | rd_o), 32'd0);
        @(negedge clk_i);
        n++;
      end
      check("R8 wait length", 32'(n), 32'(TMO));
    end else begin
      repeat (delay) begin
        check("R4 no strobe in wait", 32'(cmd_we_o | addr_we_o | rd_o), 32'd0);
        @(negedge clk_i);
      end
      if (use_evt) rdy_evt_i = 1'b1;
      else         rdy_i = 1'b1;
      @(negedge clk_i);
      rdy_evt_i = 1'b0; rdy_i = 1'b0;
      begin
        int n = 0;
        while (!done_o && n < 10) begin
          @(negedge clk_i);
          n++;
        end
        check("R7 done two cycles after status command", 32'(n), 32'd2);
      end
    end
    @(negedge clk_i);
    check("R10 busy low after done", 32'(busy_o), 32'd0);
    check("R7 done single pulse", 32'(done_o), 32'd0);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R11 reset outputs",
          {13'd0, cmd_we_o, addr_we_o, rd_o, busy_o, done_o, fail_o, timeout_o, bus_o, status_o[0]},
          32'd0);
    check("R11 reset status", 32'(status_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_erase(24'hA5B6C7, 8'hE0, 3, 1'b0, 1'b0, 1'b0);
    run_erase(24'h010203, 8'h01, 0, 1'b1, 1'b0, 1'b0);
    run_erase(24'hFFFFFF, 8'hC1, 7, 1'b0, 1'b0, 1'b1);
    run_erase(24'h123456, 8'h00, 0, 1'b0, 1'b1, 1'b0);
    run_erase(24'h00FF00, 8'h00, TMO - 1, 1'b1, 1'b0, 1'b0);
    run_erase(24'h800001, 8'h80, 5, 1'b0, 1'b0, 1'b0);

    check("R9 no leftover bus items", 32'(exp_bus.size()), 32'd0);
    check("R7 no leftover results", 32'(exp_res.size()), 32'd0);
    summary();
  end
endmodule